// File: doc/BRIEF.md
# Time-Code Host Register Block with Indirect File and Interrupts

This block is the host-side control front end of a time-code device. A host processor reaches it through an active-low chip select, two address bits and single-cycle read and write strobes. The two address bits select one of four direct registers.

Direct register 0 combines four pending interrupt flags with their enables. Reading register 0 clears the flags. Direct register 1 returns a general status byte supplied by the surrounding logic. Direct register 2 is a pointer into a file of 64 byte-wide indirect registers and can step itself forward after each access. Direct register 3 is the data window into that file.

The four interrupt sources are time-code receive, time-code transmit, video line and an internal 10-bit interval timer. The time-code codecs and the video logic sit outside the block and appear only as one-cycle event pulses. The timer takes its terminal count and its clock source from the top three indirect registers. It counts one of three event inputs and raises the timer flag each time the count completes. One interrupt output is active while any flag is set together with its enable.

Top module: `tc_host_regs`

## Requirements
- R1: After reset, every direct and indirect register reads 0, `irq_o` is low and `rdata_o` is 0.
- R2: Strobes are ignored while `cs_ni` is high. A read of address 1 returns `status_i`. Read data appears on `rdata_o` in the cycle after the read strobe and is held until the next read.
- R3: Register 0 holds the enables in bits 3:0 and the flags in bits 7:4. From the most significant bit down, the order within each group is receive, transmit, video line, timer. Writes change only the enable bits.
- R4: A one-cycle event pulse sets its flag in the following cycle. `irq_o` is high exactly when some flag and its matching enable are both set.
- R5: A read of register 0 returns the flags as they stood before the read and then clears them. An event arriving in the same cycle as that read stays pending.
- R6: Register 2 holds a 6-bit index in bits 5:0 and the auto-increment flag in bit 7. Bit 6 always reads 0.
- R7: A write to register 3 stores the byte at the current index. A read of register 3 returns the byte at the current index.
- R8: With auto-increment set, each register 3 strobe advances the index by exactly one, and the index wraps from 63 to 0. With auto-increment clear, the index does not move.
- R9: The terminal count TC is formed from indirect register 62 bits 1:0 (upper) and indirect register 61 (lower). Indirect register 63 bits 1:0 select the timer source: 0 is the 100 kHz tick, 1 is the receive clock event, 2 is the transmit clock event. The timer counts only the selected source. On every TC-th selected event it sets the timer flag and restarts from zero.
- R10: When TC is 0 or the source select is 3, the timer does not count, its count is cleared, and it never sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| addr_i | input | 2 | Direct register address |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| status_i | input | 8 | General status returned at address 1 |
| rx_evt_i | input | 1 | Time-code receive event pulse |
| tx_evt_i | input | 1 | Time-code transmit event pulse |
| vline_evt_i | input | 1 | Video line event pulse |
| tick_i | input | 1 | 100 kHz tick pulse |
| rx_clk_evt_i | input | 1 | Receive bit-clock event pulse |
| tx_clk_evt_i | input | 1 | Transmit bit-clock event pulse |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The assertions assume that all inputs are synchronous to `clk_i`. They also assume that the host never raises the read and write strobes in the same cycle, so each register 3 access is exactly one strobe. The stimulus changes every input at the falling edge and issues one strobe at a time. It keeps the timer clock inputs low outside the timer phase, so random writes to the configuration entries cannot fire the timer unexpectedly. The receive event is deliberately placed in the same cycle as a register 0 read to reach the case where the event must stay pending.

// File: rtl/tc_host_pkg.sv
package tc_host_pkg;
  localparam int DW    = 8;
  localparam int IDX_W = 6;
  localparam int DEPTH = 1 << IDX_W;
  localparam int TMR_W = 10;
  localparam int N_IRQ = 4;

  // timer configuration entries live at the top of the indirect file
  localparam int TC_LO_IDX  = DEPTH - 3;
  localparam int TC_HI_IDX  = DEPTH - 2;
  localparam int TCTRL_IDX  = DEPTH - 1;

  typedef enum logic [1:0] {
    SRC_TICK  = 2'd0,
    SRC_RXCLK = 2'd1,
    SRC_TXCLK = 2'd2,
    SRC_OFF   = 2'd3
  } tmr_src_e;

  typedef enum logic [1:0] {
    REG_IRQ  = 2'd0,
    REG_STAT = 2'd1,
    REG_PTR  = 2'd2,
    REG_DATA = 2'd3
  } dir_reg_e;
endpackage

// File: rtl/tc_irq_ctrl.sv
module tc_irq_ctrl
  import tc_host_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] evt_i,
  input  logic             clr_i,
  input  logic             en_wr_i,
  input  logic [N_IRQ-1:0] en_wdata_i,
  output logic [N_IRQ-1:0] flags_o,
  output logic [N_IRQ-1:0] en_o,
  output logic             irq_o
);
  logic [N_IRQ-1:0] flags_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      // same-cycle event wins over the clearing read
      flags_q <= (clr_i ? '0 : flags_q) | evt_i;
      if (en_wr_i) en_q <= en_wdata_i;
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign irq_o   = |(flags_q & en_q);

  AST_EVT_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i))); // R4
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(|evt_i)) |=> (flags_q == '0)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (|flags_q)) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R4
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_wr_i |=> $stable(en_q)); // R3
endmodule

// File: rtl/tc_ind_file.sv
module tc_ind_file
  import tc_host_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_wr_i,
  input  logic             data_wr_i,
  input  logic             data_acc_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             autoinc_o,
  output logic [DW-1:0]    rd_data_o,
  output logic [TMR_W-1:0] tc_o,
  output tmr_src_e         src_o
);
  localparam int TC_HI_W = TMR_W - DW;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [IDX_W-1:0] idx_q;
  logic             ai_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ai_q  <= 1'b0;
    end else if (ptr_wr_i) begin
      idx_q <= wdata_i[IDX_W-1:0];
      ai_q  <= wdata_i[DW-1];
    end else if (data_acc_i && ai_q) begin
      idx_q <= idx_q + 1'b1; // wraps naturally
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (data_wr_i && idx_q == IDX_W'(g)) mem_q[g] <= wdata_i;
    end
  end

  assign idx_o     = idx_q;
  assign autoinc_o = ai_q;
  assign rd_data_o = mem_q[idx_q];
  assign tc_o      = {mem_q[TC_HI_IDX][TC_HI_W-1:0], mem_q[TC_LO_IDX]};
  assign src_o     = tmr_src_e'(mem_q[TCTRL_IDX][1:0]);

  AST_AUTOINC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc_i && ai_q && !ptr_wr_i) |=> (idx_q == $past(idx_q) + 1'b1)); // R8
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_wr_i && !(data_acc_i && ai_q)) |=> $stable(idx_q)); // R8
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && !ai_q) |=> (rd_data_o == $past(wdata_i))); // R7
endmodule

// File: rtl/tc_interval_timer.sv
module tc_interval_timer
  import tc_host_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMR_W-1:0] tc_i,
  input  tmr_src_e         src_i,
  input  logic [2:0]       clk_evt_i, // {tx_clk, rx_clk, tick}
  output logic             fire_o
);
  logic [TMR_W-1:0] cnt_q;
  logic             fire_q, run, sel_evt;

  assign run = (tc_i != '0) && (src_i != SRC_OFF);

  always_comb begin
    unique case (src_i)
      SRC_TICK:  sel_evt = clk_evt_i[0];
      SRC_RXCLK: sel_evt = clk_evt_i[1];
      SRC_TXCLK: sel_evt = clk_evt_i[2];
      default:   sel_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (!run) begin
        cnt_q <= '0;
      end else if (sel_evt) begin
        if (cnt_q >= tc_i - 1'b1) begin
          cnt_q  <= '0;
          fire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign fire_o = fire_q;

  AST_TMR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (cnt_q == '0)); // R10
  AST_TMR_FIRE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> $past(run && sel_evt)); // R9
  AST_TMR_NO_EVT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !sel_evt) |=> (!fire_q && $stable(cnt_q))); // R9
endmodule

// File: rtl/tc_host_regs.sv
module tc_host_regs
  import tc_host_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic [7:0]    status_i,
  input  logic          rx_evt_i,
  input  logic          tx_evt_i,
  input  logic          vline_evt_i,
  input  logic          tick_i,
  input  logic          rx_clk_evt_i,
  input  logic          tx_clk_evt_i,
  output logic          irq_o
);
  logic             wr_s, rd_s;
  logic             en_wr, clr, ptr_wr, data_wr, data_acc;
  logic [N_IRQ-1:0] flags, en, evts;
  logic [IDX_W-1:0] idx;
  logic             autoinc, tmr_fire;
  logic [DW-1:0]    ind_data, rdata_q;
  logic [TMR_W-1:0] tc;
  tmr_src_e         src;

  assign wr_s     = !cs_ni && wr_i;
  assign rd_s     = !cs_ni && rd_i;
  assign en_wr    = wr_s && (addr_i == REG_IRQ);
  assign clr      = rd_s && (addr_i == REG_IRQ);
  assign ptr_wr   = wr_s && (addr_i == REG_PTR);
  assign data_wr  = wr_s && (addr_i == REG_DATA);
  assign data_acc = (wr_s || rd_s) && (addr_i == REG_DATA);
  assign evts     = {rx_evt_i, tx_evt_i, vline_evt_i, tmr_fire};

  tc_irq_ctrl u_irq (
    .clk_i, .rst_ni,
    .evt_i      (evts),
    .clr_i      (clr),
    .en_wr_i    (en_wr),
    .en_wdata_i (wdata_i[N_IRQ-1:0]),
    .flags_o    (flags),
    .en_o       (en),
    .irq_o      (irq_o)
  );

  tc_ind_file u_file (
    .clk_i, .rst_ni,
    .ptr_wr_i   (ptr_wr),
    .data_wr_i  (data_wr),
    .data_acc_i (data_acc),
    .wdata_i    (wdata_i),
    .idx_o      (idx),
    .autoinc_o  (autoinc),
    .rd_data_o  (ind_data),
    .tc_o       (tc),
    .src_o      (src)
  );

  tc_interval_timer u_tmr (
    .clk_i, .rst_ni,
    .tc_i      (tc),
    .src_i     (src),
    .clk_evt_i ({tx_clk_evt_i, rx_clk_evt_i, tick_i}),
    .fire_o    (tmr_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_s) begin
      unique case (dir_reg_e'(addr_i))
        REG_IRQ:  rdata_q <= {flags, en};
        REG_STAT: rdata_q <= status_i;
        REG_PTR:  rdata_q <= {autoinc, 1'b0, idx};
        REG_DATA: rdata_q <= ind_data;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_s |=> $stable(rdata_o)); // R2
  AST_DESELECT_NO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && (|flags)) |=> ((flags & $past(flags)) == $past(flags))); // R2
endmodule

// File: tb/tc_host_regs_tb.sv
module tc_host_regs_tb;
  logic       clk = 0, rst_ni = 0;
  logic       cs_ni = 1, wr = 0, rd = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, status = 8'h00;
  logic       rx_evt = 0, tx_evt = 0, vl_evt = 0, tick = 0, rxc = 0, txc = 0;
  logic       irq;
  int         total = 0, fails = 0;

  logic [7:0] mem_m [64];
  logic [5:0] idx_m;
  logic       ai_m;

  always #2 clk = ~clk; // 250 MHz

  tc_host_regs u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .status_i(status), .rx_evt_i(rx_evt), .tx_evt_i(tx_evt),
    .vline_evt_i(vl_evt), .tick_i(tick), .rx_clk_evt_i(rxc),
    .tx_clk_evt_i(txc), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d, logic cs = 1);
    @(negedge clk);
    cs_ni = !cs; addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0; cs_ni = 1;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_ni = 0; addr = a; rd = 1;
    @(negedge clk);
    rd = 0; cs_ni = 1;
    d = rdata;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  function automatic logic [7:0] ptr_val(logic ai, logic [5:0] ix);
    return {ai, 1'b0, ix};
  endfunction

  task automatic m_ptr(logic [7:0] d);
    wr_reg(2'd2, d);
    idx_m = d[5:0]; ai_m = d[7];
  endtask

  task automatic m_wdata(logic [7:0] d);
    wr_reg(2'd3, d);
    mem_m[idx_m] = d;
    if (ai_m) idx_m++;
  endtask

  task automatic m_rdata(string req);
    logic [7:0] d;
    rd_reg(2'd3, d);
    chk(req, d, mem_m[idx_m]);
    if (ai_m) idx_m++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_2008));
    for (int i = 0; i < 64; i++) mem_m[i] = 0;
    idx_m = 0; ai_m = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 irq", irq, 0);
    rd_reg(2'd0, d); chk("R1 reg0", d, 0);
    rd_reg(2'd2, d); chk("R1 reg2", d, 0);
    m_rdata("R1 ind0");

    // R2 status and deselect
    status = 8'hA5;
    rd_reg(2'd1, d); chk("R2 status", d, 8'hA5);
    repeat (2) @(negedge clk);
    chk("R2 rdata held", rdata, 8'hA5);
    wr_reg(2'd0, 8'h0F, 0);
    rd_reg(2'd0, d); chk("R2 deselected write ignored", d, 0);

    // R3 enables, status bits not writable
    wr_reg(2'd0, 8'hFA);
    rd_reg(2'd0, d); chk("R3 enables only", d, 8'h0A);

    // R4 events and irq: enables rx(3), vline(1)
    pulse(tx_evt);
    @(negedge clk);
    chk("R4 tx flag not enabled irq", irq, 0);
    pulse(vl_evt);
    @(negedge clk);
    chk("R4 irq on enabled flag", irq, 1);
    // R5 read returns old flags, coincident rx stays pending
    @(negedge clk);
    cs_ni = 0; addr = 0; rd = 1; rx_evt = 1;
    @(negedge clk);
    rd = 0; cs_ni = 1; rx_evt = 0;
    chk("R5 pre-clear flags", rdata, 8'h6A);
    chk("R5 irq from coincident rx", irq, 1);
    rd_reg(2'd0, d); chk("R5 rx pending after clear", d, 8'h8A);
    rd_reg(2'd0, d); chk("R5 cleared", d, 8'h0A);
    chk("R5 irq low", irq, 0);

    // R6 pointer format, bit 6 reads 0
    m_ptr(8'hFF);
    rd_reg(2'd2, d); chk("R6 ptr", d, 8'hBF);
    // R8 wrap 63 -> 0
    m_wdata(8'h11);
    rd_reg(2'd2, d); chk("R8 wrap", d, ptr_val(1, 0));
    m_wdata(8'h22);
    m_ptr(8'h3F);
    m_rdata("R7 read back at 63");
    rd_reg(2'd2, d); chk("R8 no autoinc", d, ptr_val(0, 63));
    m_ptr(8'h80);
    m_rdata("R7 read 0 autoinc");
    rd_reg(2'd2, d); chk("R8 single step per strobe", d, ptr_val(1, 1));

    // random indirect traffic, timer clocks held low
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: m_ptr(8'($urandom));
        1: m_wdata(8'($urandom));
        2: m_rdata("R7 random read");
        default: begin
          rd_reg(2'd2, d); chk("R6 random ptr", d, ptr_val(ai_m, idx_m));
        end
      endcase
    end

    // R9 timer: TC=3, source rx clock
    wr_reg(2'd0, 8'h01);
    rd_reg(2'd0, d);
    m_ptr(8'hBD);
    m_wdata(8'h03); m_wdata(8'h00); m_wdata(8'h01);
    pulse(tick); pulse(txc);
    pulse(rxc); pulse(rxc);
    @(negedge clk);
    chk("R9 no fire before TC", irq, 0);
    pulse(rxc);
    @(negedge clk);
    chk("R9 fire at TC", irq, 1);
    rd_reg(2'd0, d); chk("R9 timer flag", d, 8'h11);
    for (int k = 0; k < 3; k++) pulse(rxc);
    @(negedge clk);
    rd_reg(2'd0, d); chk("R9 restart fires again", d, 8'h11);
    // TC = 0x102 from upper field, source tick
    m_ptr(8'hBD);
    m_wdata(8'h02); m_wdata(8'h01); m_wdata(8'h00);
    for (int k = 0; k < 257; k++) pulse(tick);
    @(negedge clk);
    chk("R9 no fire at 257 of 258", irq, 0);
    pulse(tick);
    @(negedge clk);
    chk("R9 fire at 258", irq, 1);
    rd_reg(2'd0, d);

    // R10 disable via source 3, then TC 0
    m_ptr(8'hBD);
    m_wdata(8'h01); m_wdata(8'h00); m_wdata(8'h03);
    for (int k = 0; k < 4; k++) begin pulse(tick); pulse(rxc); pulse(txc); end
    @(negedge clk);
    rd_reg(2'd0, d); chk("R10 source off", d, 8'h01);
    m_ptr(8'hBD);
    m_wdata(8'h00); m_wdata(8'h00); m_wdata(8'h02);
    for (int k = 0; k < 4; k++) pulse(txc);
    @(negedge clk);
    rd_reg(2'd0, d); chk("R10 TC zero", d, 8'h01);
    chk("R10 irq low", irq, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule